// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides an incoming high-rate clock by a programmable ratio and marks the end of each division period with a single-clock pulse, which a phase comparator sets against a reference. The ratio is formed the way a pulse-swallow synthesizer builds it. A fixed power-of-two prestage (divide by 8 by default) feeds a stage that can divide by 32 or by 33. A 10-bit main count M and a 5-bit swallow count S control that stage. In the first S main-count steps of every period the stage divides by 33, and in the remaining M−S steps it divides by 32. The total ratio is therefore P×(32·M+S), where P is the prestage factor.

All stages are plain binary counters clocked by the one input clock. The M and S inputs may change at any time. The block samples them only when a period ends, so a period in progress is never shortened or stretched. An M value below 32 cannot give a proper pulse-swallow count. Such a value is raised to 32 and reported on a status output.

Top module: `swallow_divider`

## Requirements
- R1: While reset is held low, and on the first clock after it, `div_pulse` and `m_low_flag` are both 0.
- R2: For legal settings (32 ≤ M ≤ 1023, 0 ≤ S ≤ 31), successive rising edges of `div_pulse` are exactly P×(32·M+S) clocks apart, where P = 2^PRE_BITS (8 by default).
- R3: `div_pulse` is high for exactly one clock per period.
- R4: Both range endpoints divide correctly: M=32, S=0 gives P×1024 clocks, and M=1023, S=31 gives P×32767 clocks.
- R5: A change of M or S takes effect only at a period boundary. The period in progress keeps the old ratio. Values present in the last clock of a period set the length of the next period.
- R6: An M input below 32 is treated as 32 when it is loaded. `m_low_flag` goes to 1 one clock after such a value is presented and back to 0 one clock after a legal value is presented.
- R7: After reset is released, with the settings held during reset, the first `div_pulse` appears on the N-th clock, where N is the ratio from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock being divided |
| rst_n | input | 1 | Synchronous reset, active low |
| m_set | input | 10 | Main count M, binary |
| s_set | input | 5 | Swallow count S, binary |
| div_pulse | output | 1 | One-clock pulse at the end of each division period |
| m_low_flag | output | 1 | Set while the M input is below 32 |

## Verification
The end of a period and the loading of new settings can fall in the same clock. That clock is the one in which the main counter reaches its terminal count. The bench predicts that clock from the expected ratio and drives new M and S values in exactly that cycle. It then checks two things: the pulse still arrives at the old spacing, and the following spacing matches the new ratio. A second case drives new values in the middle of a period and expects them to have no effect until the next boundary. A third case gives an M value below 32, which the block must clamp, and checks both the status flag and the resulting spacing.

// File: rtl/swallow_div_pkg.sv
// Shared sizing constants for the pulse-swallow divider.
// Assumes the dual-modulus stage is 2^MOD_BITS / 2^MOD_BITS+1 and that
// the lowest legal main count equals 2^MOD_BITS.
package swallow_div_pkg;
    localparam int MAIN_W   = 10;
    localparam int SWAL_W   = 5;
    localparam int MOD_BITS = 5;
    localparam int MAIN_MIN = 1 << MOD_BITS;
    localparam int PRE_BITS = 3;
endpackage

// File: rtl/swallow_div_prestage.sv
// Fixed power-of-two prestage: emits one tick every 2^PRE_BITS clocks.
// Assumes PRE_BITS >= 1; counts freely from reset.
module swallow_div_prestage #(
    parameter int PRE_BITS = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [PRE_BITS-1:0] cnt;

    // Tick in the last state of the binary count.
    always_comb tick = &cnt;

    // Free-running prestage counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/swallow_div_dual_mod.sv
// Dual-modulus stage: counts prestage ticks and wraps after 2^MOD_BITS
// ticks, or after one more when swallow is high.
// Assumes swallow only changes on the edge where wrap is taken.
module swallow_div_dual_mod #(
    parameter int MOD_BITS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic swallow,
    output logic wrap
);
    localparam int CW = MOD_BITS + 1;
    localparam logic [CW-1:0] LAST_SHORT = CW'((1 << MOD_BITS) - 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(1 << MOD_BITS);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Choose the terminal state from the current modulus.
    always_comb begin
        last = swallow ? LAST_LONG : LAST_SHORT;
        wrap = adv && (cnt == last);
    end

    // Modulus counter advanced by prestage ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (adv)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/swallow_div_main_ctl.sv
// Main and swallow control: counts dual-modulus wraps up to the active M,
// requests the long modulus for the first S of them, and loads new
// (clamped) settings only at the end of a period.
// Assumes SWAL_W < MAIN_W and MAIN_MIN > 2^SWAL_W - 1.
module swallow_div_main_ctl #(
    parameter int MAIN_W   = 10,
    parameter int SWAL_W   = 5,
    parameter int MAIN_MIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] m_set,
    input  logic [SWAL_W-1:0] s_set,
    input  logic              dm_wrap,
    output logic              swallow,
    output logic              period_end,
    output logic              range_err,
    output logic [MAIN_W-1:0] m_act,
    output logic [SWAL_W-1:0] s_act
);
    localparam logic [MAIN_W-1:0] MIN_V = MAIN_W'(MAIN_MIN);
    localparam logic [MAIN_W-1:0] ONE_V = MAIN_W'(1);
    localparam int                PAD_W = MAIN_W - SWAL_W;

    logic [MAIN_W-1:0] main_cnt;
    logic [MAIN_W-1:0] m_eff;
    logic              m_low;

    // Clamp the requested main count to the legal floor.
    always_comb begin
        m_low = (m_set < MIN_V);
        m_eff = m_low ? MIN_V : m_set;
    end

    // Long modulus while fewer than S main steps are done; period end
    // when the last main step wraps.
    always_comb begin
        swallow    = (main_cnt < {{PAD_W{1'b0}}, s_act});
        period_end = dm_wrap && (main_cnt == m_act - ONE_V);
    end

    // Main step counter and boundary loading of settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_cnt  <= '0;
            m_act     <= m_eff;
            s_act     <= s_set;
            range_err <= 1'b0;
        end else begin
            range_err <= m_low;
            if (period_end) begin
                main_cnt <= '0;
                m_act    <= m_eff;
                s_act    <= s_set;
            end else if (dm_wrap) begin
                main_cnt <= main_cnt + ONE_V;
            end
        end
    end
endmodule

// File: rtl/swallow_divider.sv
// Top of the pulse-swallow divider: prestage, dual-modulus stage and
// main/swallow control in cascade, with a registered one-clock output
// pulse per period of 2^PRE_BITS * (2^MOD_BITS * M + S) clocks.
// Assumes settings are binary and may change at any clock.
module swallow_divider
    import swallow_div_pkg::*;
#(
    parameter int PRE_BITS = swallow_div_pkg::PRE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] m_set,
    input  logic [SWAL_W-1:0] s_set,
    output logic              div_pulse,
    output logic              m_low_flag
);
    logic              pre_tick;
    logic              dm_wrap;
    logic              swallow;
    logic              period_end;
    logic [MAIN_W-1:0] m_act;
    logic [SWAL_W-1:0] s_act;

    swallow_div_prestage #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (pre_tick)
    );

    swallow_div_dual_mod #(.MOD_BITS(MOD_BITS)) u_dm (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (pre_tick),
        .swallow(swallow),
        .wrap   (dm_wrap)
    );

    swallow_div_main_ctl #(
        .MAIN_W  (MAIN_W),
        .SWAL_W  (SWAL_W),
        .MAIN_MIN(MAIN_MIN)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .m_set     (m_set),
        .s_set     (s_set),
        .dm_wrap   (dm_wrap),
        .swallow   (swallow),
        .period_end(period_end),
        .range_err (m_low_flag),
        .m_act     (m_act),
        .s_act     (s_act)
    );

    // Register the period end into a clean one-clock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) div_pulse <= 1'b0;
        else        div_pulse <= period_end;
    end
endmodule

// File: rtl/swallow_divider_chk.sv
// Property checker for swallow_divider, attached by bind.
// Assumes synchronous active-low reset; past_ok gates $past use.
module swallow_divider_chk
    import swallow_div_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MAIN_W-1:0] m_set,
    input logic              div_pulse,
    input logic              m_low_flag,
    input logic              pre_tick,
    input logic              dm_wrap,
    input logic              period_end,
    input logic [MAIN_W-1:0] m_act,
    input logic [SWAL_W-1:0] s_act
);
    logic past_ok;

    // One clock of history exists after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3: pulse never lasts two clocks.
    a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R2: a period ends only on a prestage tick that also wraps the modulus stage.
    a_r2_end_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> (dm_wrap && pre_tick));

    // R2: the output pulse follows the period end by one clock.
    a_r2_pulse_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (div_pulse == $past(period_end)));

    // R5: active settings hold between period boundaries.
    a_r5_hold_main: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(period_end)) |-> $stable(m_act));
    a_r5_hold_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(period_end)) |-> $stable(s_act));

    // R6: the active main count never drops below the floor.
    a_r6_clamp_floor: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (m_act >= MAIN_W'(MAIN_MIN)));

    // R6: the flag follows the M input one clock later.
    a_r6_flag_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (m_low_flag == ($past(m_set) < MAIN_W'(MAIN_MIN))));
endmodule

bind swallow_divider swallow_divider_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_set     (m_set),
    .div_pulse (div_pulse),
    .m_low_flag(m_low_flag),
    .pre_tick  (pre_tick),
    .dm_wrap   (dm_wrap),
    .period_end(period_end),
    .m_act     (m_act),
    .s_act     (s_act)
);

// File: tb/swallow_divider_bench.sv
// Self-checking bench: directed endpoints plus seeded random settings,
// with spacing computed from the ratio formula. Uses a 2x prestage so
// the top-endpoint period fits the run length.
module swallow_divider_bench;
    localparam int PB = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] m_set = 10'd32;
    logic [4:0] s_set = 5'd0;
    logic       div_pulse;
    logic       m_low_flag;

    int checks = 0;
    int errors = 0;
    int cur_n  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    swallow_divider #(.PRE_BITS(PB)) u_swallow_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .m_set     (m_set),
        .s_set     (s_set),
        .div_pulse (div_pulse),
        .m_low_flag(m_low_flag)
    );

    function automatic int exp_n(input int m, input int s);
        int mm;
        mm = (m < 32) ? 32 : m;
        return (1 << PB) * (32 * mm + s);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic count_to_pulse(input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_pulse && n <= lim);
    endtask

    // Reset with given settings, check idle outputs, then the first pulse.
    task automatic reset_with(input int m, input int s);
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        m_set = 10'(m);
        s_set = 5'(s);
        repeat (3) @(negedge clk);
        chk("R1 pulse in reset", div_pulse, 0);
        chk("R1 flag in reset", m_low_flag, 0);
        rst_n = 1'b1;
        cur_n = exp_n(m, s);
        count_to_pulse(cur_n + 10, n);
        chk("R7 first pulse after reset", n, cur_n);
    endtask

    // From a pulse, drive new settings in the final clock of the period.
    task automatic boundary_step(input int m, input int s);
        repeat (cur_n - 1) @(negedge clk);
        m_set = 10'(m);
        s_set = 5'(s);
        @(negedge clk);
        chk("R2/R5 old spacing at boundary load", div_pulse, 1);
        cur_n = exp_n(m, s);
    endtask

    initial begin
        int n;
        int m;
        int s;
        void'($urandom(32'd4242));

        // R4 upper endpoint, R7 first pulse, R1 reset values
        reset_with(1023, 31);
        // R4 lower endpoint
        reset_with(32, 0);
        @(negedge clk);
        chk("R3 pulse one clock wide", div_pulse, 0);
        count_to_pulse(cur_n + 10, n);
        chk("R4 lower endpoint spacing", n + 1, cur_n);

        // R2 and R5: random settings loaded in the period's last clock
        for (int i = 0; i < 6; i++) begin
            m = 32 + int'($urandom_range(48, 0));
            s = int'($urandom_range(31, 0));
            boundary_step(m, s);
        end
        boundary_step(40, 31);
        count_to_pulse(cur_n + 10, n);
        chk("R2 spacing with new settings", n, cur_n);

        // R5: mid-period change has no effect on the current period
        repeat (50) @(negedge clk);
        m_set = 10'd45;
        s_set = 5'd3;
        count_to_pulse(cur_n + 10, n);
        chk("R5 mid-period change ignored", n + 50, cur_n);
        cur_n = exp_n(45, 3);
        count_to_pulse(cur_n + 10, n);
        chk("R5 new ratio after boundary", n, cur_n);

        // R6: clamp of a low M and the status flag
        repeat (20) @(negedge clk);
        m_set = 10'd5;
        s_set = 5'd7;
        @(negedge clk);
        chk("R6 flag raised", m_low_flag, 1);
        count_to_pulse(cur_n + 10, n);
        chk("R6 current period unchanged", n + 21, cur_n);
        cur_n = exp_n(5, 7);
        m_set = 10'd40;
        @(negedge clk);
        chk("R6 flag cleared", m_low_flag, 0);
        count_to_pulse(cur_n + 10, n);
        chk("R6 clamped spacing", n + 1, cur_n);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule